// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block holds the interrupt logic for one bank of up to 32 general-purpose pins. Each pin owns a control word in which a two-bit trigger field selects whether a rising edge, a falling edge, either edge, or nothing raises that pin's pending flag. Pending flags live in a status word that software clears by writing ones. A mask word decides which pending flags reach the single bank interrupt line. The mask is changed through two separate addresses: one sets bits and the other clears them.

The pin inputs are assumed to be already synchronized to `clk`. Edges are found by comparing each pin's level with its level one clock earlier. Register access is a plain write strobe with a combinational read path. Several banks can share one address decoder, because the bank index is a parameter that moves the bank's word addresses.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every trigger field reads 0, the mask reads all ones, the status reads all zeros, and `bank_irq` is low.
- R2: The control word of pin p sits at byte address 0x100 + 4*(32*BANK_IDX + p). Its trigger field is bits [4:3]. Every other bit reads 0 and ignores writes.
- R3: Trigger code 1 (rising): a 0-to-1 change on a pin, seen on consecutive clocks, sets that pin's status bit at the clock edge where the new level is first sampled. A 1-to-0 change does not set it.
- R4: Trigger code 2 (falling): a 1-to-0 change sets the status bit. A 0-to-1 change does not.
- R5: Trigger code 3 (both): a change in either direction sets the status bit.
- R6: Trigger code 0: no change on that pin sets its status bit.
- R7: The status word sits at 0x80 + 4*BANK_IDX, with bit p belonging to pin p. Writing a 1 clears that bit. Writing a 0 leaves it unchanged.
- R8: Writing ones to 0xA0 + 4*BANK_IDX sets those mask bits. Writing ones to 0xC0 + 4*BANK_IDX clears those mask bits. Zeros written to either address leave the mask unchanged. Both addresses read back the mask.
- R9: `bank_irq` is high exactly while some status bit is set whose mask bit is 0. Status bits latch edges while masked, and masking gates only the line.
- R10: When a pin's edge and a write-1 clear of its status bit fall in the same cycle, the bit stays set. Other bits named in that write are cleared.
- R11: Any address not named in R2, R7 or R8 reads 0, and writes to it change no state. This includes misaligned addresses and another bank's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| bank_irq | output | 1 | Bank interrupt, high while an unmasked status bit is set |

## Verification
A wrong trigger decode, or a status bit that does not hold its value, appears in the status word at the first read after the clock edge that sampled the pin change, which is one cycle after the pin moves. A corrupted mask or a bad combine term shows on `bank_irq` in that same cycle. The bench sweeps every pin through all four trigger codes and both edge directions. It also drives a clear and an edge into the same cycle. Any error in the per-pin state therefore shows up within a cycle as a status or line mismatch on the pin concerned.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // trigger field encoding: bit 0 arms rising edges, bit 1 arms falling edges
   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_BOTH = 2'd3
   } trig_mode_e;

   localparam int TRIG_LSB = 3;
   localparam int TRIG_MSB = 4;

   // word address bases of the register groups
   localparam int CTRL_BASE  = 'h100;
   localparam int STAT_BASE  = 'h080;
   localparam int MSET_BASE  = 'h0A0;
   localparam int MCLR_BASE  = 'h0C0;
   localparam int PIN_STRIDE = 32;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_STAT,
      SEL_MSET,
      SEL_MCLR
   } reg_sel_e;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
   import gpio_irq_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NUM_PINS = 32,
   parameter int BANK_IDX = 0,
   parameter int PIN_W    = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic [PIN_W-1:0]  pin_idx
);

   localparam logic [ADDR_W-1:0] CTRL_LO = ADDR_W'(CTRL_BASE + 4 * PIN_STRIDE * BANK_IDX);
   localparam logic [ADDR_W-1:0] CTRL_HI = ADDR_W'(CTRL_BASE + 4 * PIN_STRIDE * BANK_IDX + 4 * NUM_PINS);
   localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_BASE + 4 * BANK_IDX);
   localparam logic [ADDR_W-1:0] MSET_A  = ADDR_W'(MSET_BASE + 4 * BANK_IDX);
   localparam logic [ADDR_W-1:0] MCLR_A  = ADDR_W'(MCLR_BASE + 4 * BANK_IDX);

   logic [ADDR_W-1:0] offs;
   logic              aligned;

   assign offs    = addr - CTRL_LO;
   assign aligned = (addr[1:0] == 2'b00);

   always_comb begin
      sel     = SEL_NONE;
      pin_idx = PIN_W'(offs >> 2);
      if (aligned && (addr >= CTRL_LO) && (addr < CTRL_HI)) begin
         sel = SEL_CTRL;
      end else if (addr == STAT_A) begin
         sel = SEL_STAT;
      end else if (addr == MSET_A) begin
         sel = SEL_MSET;
      end else if (addr == MCLR_A) begin
         sel = SEL_MCLR;
      end
   end

endmodule

// File: rtl/gpio_irq_trig_cfg.sv
module gpio_irq_trig_cfg
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int PIN_W    = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr,
   input  logic [PIN_W-1:0]         cfg_pin,
   input  logic [1:0]               cfg_trig,
   output logic [NUM_PINS-1:0][1:0] trig_q
);

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trig_q[g] <= TRIG_OFF;
         end else if (cfg_wr && (cfg_pin == PIN_W'(g))) begin
            trig_q[g] <= cfg_trig;
         end
      end
   end

endmodule

// File: rtl/gpio_irq_edge_det.sv
module gpio_irq_edge_det #(
   parameter int NUM_PINS = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PINS-1:0]      pin_lvl,
   input  logic [NUM_PINS-1:0][1:0] trig,
   output logic [NUM_PINS-1:0]      hit
);

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= pin_lvl;
      end
   end

   assign rise = pin_lvl & ~prev_q;
   assign fall = ~pin_lvl & prev_q;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      assign hit[g] = (trig[g][0] & rise[g]) | (trig[g][1] & fall[g]);
   end

endmodule

// File: rtl/gpio_irq_stat_mask.sv
module gpio_irq_stat_mask #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] hit,
   input  logic [NUM_PINS-1:0] stat_clr,
   input  logic [NUM_PINS-1:0] mask_set,
   input  logic [NUM_PINS-1:0] mask_clr,
   output logic [NUM_PINS-1:0] status_q,
   output logic [NUM_PINS-1:0] mask_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= '1;
      end else begin
         // a fresh edge overrides a clear aimed at the same bit
         status_q <= (status_q & ~stat_clr) | hit;
         mask_q   <= (mask_q | mask_set) & ~mask_clr;
      end
   end

   assert_edge_sticks_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

   assert_w1c_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_clr) |=> ((status_q & $past(stat_clr) & ~$past(hit)) == '0));

   assert_mask_set_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (|mask_set) |=> ((mask_q & $past(mask_set)) == $past(mask_set)));

   assert_mask_clr_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (|mask_clr) |=> ((mask_q & $past(mask_clr)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_PINS = 32,
   parameter int BANK_IDX = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_lvl,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_wr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                bank_irq
);

   localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   if (NUM_PINS < 1 || NUM_PINS > PIN_STRIDE) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..32");
   end
   if (DATA_W < NUM_PINS || DATA_W <= TRIG_MSB) begin : g_bad_data
      $error("DATA_W too narrow for the bank");
   end
   if (BANK_IDX < 0 || BANK_IDX > 7) begin : g_bad_bank
      $error("BANK_IDX must lie in 0..7");
   end
   if ((CTRL_BASE + 4 * PIN_STRIDE * (BANK_IDX + 1)) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W cannot reach the control words");
   end

   reg_sel_e                 sel;
   logic [PIN_W-1:0]         pin_idx;
   logic [NUM_PINS-1:0][1:0] trig_q;
   logic [NUM_PINS-1:0]      hit;
   logic [NUM_PINS-1:0]      status_q;
   logic [NUM_PINS-1:0]      mask_q;
   logic [NUM_PINS-1:0]      wvec;
   logic [NUM_PINS-1:0]      stat_clr;
   logic [NUM_PINS-1:0]      mask_set;
   logic [NUM_PINS-1:0]      mask_clr;

   gpio_irq_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_PINS(NUM_PINS),
      .BANK_IDX(BANK_IDX),
      .PIN_W   (PIN_W)
   ) decode_i (
      .addr   (reg_addr),
      .sel    (sel),
      .pin_idx(pin_idx)
   );

   gpio_irq_trig_cfg #(
      .NUM_PINS(NUM_PINS),
      .PIN_W   (PIN_W)
   ) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (reg_wr && (sel == SEL_CTRL)),
      .cfg_pin (pin_idx),
      .cfg_trig(reg_wdata[TRIG_MSB:TRIG_LSB]),
      .trig_q  (trig_q)
   );

   gpio_irq_edge_det #(
      .NUM_PINS(NUM_PINS)
   ) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_lvl(pin_lvl),
      .trig   (trig_q),
      .hit    (hit)
   );

   assign wvec     = reg_wdata[NUM_PINS-1:0];
   assign stat_clr = (reg_wr && (sel == SEL_STAT)) ? wvec : '0;
   assign mask_set = (reg_wr && (sel == SEL_MSET)) ? wvec : '0;
   assign mask_clr = (reg_wr && (sel == SEL_MCLR)) ? wvec : '0;

   gpio_irq_stat_mask #(
      .NUM_PINS(NUM_PINS)
   ) sm_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .stat_clr(stat_clr),
      .mask_set(mask_set),
      .mask_clr(mask_clr),
      .status_q(status_q),
      .mask_q  (mask_q)
   );

   always_comb begin
      unique case (sel)
         SEL_CTRL: reg_rdata = DATA_W'({trig_q[pin_idx], 3'b000});
         SEL_STAT: reg_rdata = DATA_W'(status_q);
         SEL_MSET,
         SEL_MCLR: reg_rdata = DATA_W'(mask_q);
         default:  reg_rdata = '0;
      endcase
   end

   assign bank_irq = |(status_q & ~mask_q);

   assert_irq_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !bank_irq);

   assert_irq_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      bank_irq |-> (|status_q));

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb_top;

   localparam int NP = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP-1:0] pins = '0;
   logic [11:0] reg_addr = 12'hFFC;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bank_irq;

   int vec_cnt = 0;
   int err_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_bank dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_lvl  (pins),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .bank_irq (bank_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         err_cnt++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic set_pin(input int p, input logic v);
      @(negedge clk);
      pins[p] = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         err_cnt++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_reg(12'h080, rd); check("R1 status", rd, 32'h0);
      rd_reg(12'h0A0, rd); check("R1 mask", rd, 32'hFFFF_FFFF);
      rd_reg(12'h100, rd); check("R1 ctrl pin0", rd, 32'h0);
      rd_reg(12'h17C, rd); check("R1 ctrl pin31", rd, 32'h0);
      check("R1 irq", {31'b0, bank_irq}, 32'h0);

      // R11 unmapped addresses
      wr_reg(12'h084, 32'hFFFF_FFFF);
      wr_reg(12'h180, 32'hFFFF_FFFF);
      wr_reg(12'h102, 32'hFFFF_FFFF);
      wr_reg(12'h0C2, 32'hFFFF_FFFF);
      rd_reg(12'h084, rd); check("R11 other bank status reads 0", rd, 32'h0);
      rd_reg(12'h180, rd); check("R11 other bank ctrl reads 0", rd, 32'h0);
      rd_reg(12'h102, rd); check("R11 misaligned reads 0", rd, 32'h0);
      rd_reg(12'h0A0, rd); check("R11 mask untouched", rd, 32'hFFFF_FFFF);
      rd_reg(12'h100, rd); check("R11 ctrl untouched", rd, 32'h0);

      // R8 mask set/clear through separate words
      wr_reg(12'h0C0, 32'hFFFF_FFFF);
      rd_reg(12'h0C0, rd); check("R8 clear all", rd, 32'h0);
      wr_reg(12'h0A0, 32'h0000_00F0);
      rd_reg(12'h0A0, rd); check("R8 set F0", rd, 32'h0000_00F0);
      wr_reg(12'h0A0, 32'h0000_000F);
      rd_reg(12'h0C0, rd); check("R8 set accumulates", rd, 32'h0000_00FF);
      wr_reg(12'h0C0, 32'h0000_003C);
      rd_reg(12'h0A0, rd); check("R8 clear subset", rd, 32'h0000_00C3);
      wr_reg(12'h0C0, 32'hFFFF_FFFF);

      // R2..R6, R9 sweep: every pin, every trigger code, both edges
      for (int p = 0; p < NP; p++) begin
         for (int t = 0; t < 4; t++) begin
            logic [31:0] exp_r;
            logic [31:0] exp_f;
            exp_r = ((t & 1) != 0) ? (32'h1 << p) : 32'h0;
            exp_f = ((t & 2) != 0) ? (32'h1 << p) : 32'h0;
            wr_reg(12'(12'h100 + 4 * p), 32'hFFFF_FFE7 | (32'(t) << 3));
            rd_reg(12'(12'h100 + 4 * p), rd);
            check("R2 ctrl readback", rd, 32'(t) << 3);
            set_pin(p, 1'b1);
            rd_reg(12'h080, rd);
            check("R3 R5 R6 rising edge", rd, exp_r);
            check("R9 irq after rise", {31'b0, bank_irq}, {31'b0, exp_r != 0});
            wr_reg(12'h080, 32'hFFFF_FFFF);
            set_pin(p, 1'b0);
            rd_reg(12'h080, rd);
            check("R4 R5 R6 falling edge", rd, exp_f);
            check("R9 irq after fall", {31'b0, bank_irq}, {31'b0, exp_f != 0});
            wr_reg(12'h080, 32'hFFFF_FFFF);
            wr_reg(12'(12'h100 + 4 * p), 32'h0);
         end
      end

      // R9 latching while masked, R7 zero write has no effect
      wr_reg(12'h11C, 32'h0000_0018);
      wr_reg(12'h0A0, 32'h0000_0080);
      rd_reg(12'h0A0, rd); check("R8 single mask bit", rd, 32'h0000_0080);
      set_pin(7, 1'b1);
      rd_reg(12'h080, rd); check("R9 latches while masked", rd, 32'h0000_0080);
      check("R9 masked line low", {31'b0, bank_irq}, 32'h0);
      wr_reg(12'h0C0, 32'h0000_0080);
      #1;
      check("R9 unmask raises line", {31'b0, bank_irq}, 32'h1);
      wr_reg(12'h080, 32'h0);
      rd_reg(12'h080, rd); check("R7 zero write keeps bit", rd, 32'h0000_0080);
      wr_reg(12'h080, 32'h0000_0080);
      rd_reg(12'h080, rd); check("R7 one write clears", rd, 32'h0);
      check("R9 line drops", {31'b0, bank_irq}, 32'h0);

      // R10 edge and clear in the same cycle
      wr_reg(12'h10C, 32'h0000_0008);
      wr_reg(12'h114, 32'h0000_0008);
      set_pin(5, 1'b1);
      rd_reg(12'h080, rd); check("R10 setup bit5", rd, 32'h0000_0020);
      @(negedge clk);
      pins[3]   = 1'b1;
      reg_addr  = 12'h080;
      reg_wdata = 32'h0000_0028;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      rd_reg(12'h080, rd); check("R10 edge wins over clear", rd, 32'h0000_0008);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

endmodule